// File: doc/BRIEF.md
# Synchronous Read Port Output Register

This block is the data-out register stage that sits behind a synchronous RAM read port. Each cycle it decides whether to capture the raw word from the array, to load a reset constant, or to keep its current contents. The decision depends on a clock enable, a read enable, a synchronous reset, an asynchronous reset and a flag that says the same port is writing in this cycle.

Parameters set what the register holds after power-up and what each reset loads. The power-up content can be left unspecified, all zeros or a chosen constant. Each reset can be absent, load zeros, load a chosen constant or reload the power-up content. A priority parameter sets how the synchronous reset ranks against the two enables. A further option stops the synchronous reset from acting in cycles where the port writes. A memory wrapper instantiates one copy of the block per synchronous read port, with the parameters it needs.

Top module: `rd_out_reg`

## Requirements
- R1: While `rst_ni` is low, `rd_data_o` holds the power-up value: `INIT_VAL` for kind value and zero for kind zero. Kind none leaves the content unspecified. The kind encoding is 0 none, 1 zero, 2 value, 3 init.
- R2: If `ARST_KIND` is not none, a high `arst_i` sets `rd_data_o` to the asynchronous reset value at once, with no clock edge. The value is 0 for zero, `ARST_VAL` for value and the power-up value for init. The output keeps that value for as long as `arst_i` stays high, whatever the other inputs do.
- R3: With `ARST_KIND` none, `arst_i` has no effect on `rd_data_o`.
- R4: When `clk_en_i` and `rd_en_i` are both high and no synchronous reset acts, `rd_data_o` takes `arr_data_i` on the next rising edge.
- R5: When neither a read nor a synchronous reset acts, `rd_data_o` keeps its value across the edge.
- R6: With `SRST_PRIO` ungated (encoding 0), a high `srst_i` loads the synchronous reset value whatever the levels of `clk_en_i` and `rd_en_i`.
- R7: With `SRST_PRIO` clock-enable-gated (encoding 1), `srst_i` acts only when `clk_en_i` is high. It then overrides `rd_en_i`.
- R8: With `SRST_PRIO` read-enable-gated (encoding 2), `srst_i` acts only when `clk_en_i` and `rd_en_i` are both high.
- R9: With `SRST_BLOCK_WR` set, `srst_i` is ignored in any cycle where `wr_active_i` is high. The cycle then behaves as a plain read or hold.
- R10: The synchronous reset loads 0 for kind zero, `SRST_VAL` for kind value and the power-up value for kind init.
- R11: With `SRST_KIND` none, `srst_i` has no effect, and the enables alone decide between read and hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock, rising edge |
| rst_ni | input | 1 | Active-low power-up reset, loads the initial value |
| arst_i | input | 1 | Asynchronous read-data reset, active high |
| clk_en_i | input | 1 | Clock enable of the port |
| rd_en_i | input | 1 | Read enable of the port |
| srst_i | input | 1 | Synchronous read-data reset, active high |
| wr_active_i | input | 1 | Port performs a write this cycle |
| arr_data_i | input | WIDTH | Raw word from the memory array |
| rd_data_o | output | WIDTH | Registered read data |

## Verification
Four copies of the block, one for each priority ordering plus one with both resets removed, see the same stimulus. This lets each enable/reset combination tell the orderings apart in a single cycle. Directed steps set the synchronous reset against each enable on its own, then against a write with and without the blocking option, then an asynchronous pulse with and without a clock edge. A seeded random phase then sweeps all enable, reset and write combinations. Each cycle brings fresh array data, so a wrong load, hold or reset shows up as a value that differs from the model.

// File: rtl/rdreg_pkg.sv
package rdreg_pkg;
  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_ZERO  = 2'd1,
    RK_VALUE = 2'd2,
    RK_INIT  = 2'd3
  } rst_kind_e;

  typedef enum logic [1:0] {
    SP_UNGATED = 2'd0,
    SP_GATE_CE = 2'd1,
    SP_GATE_RE = 2'd2
  } srst_prio_e;
endpackage

// File: rtl/rdreg_ctrl.sv
module rdreg_ctrl
  import rdreg_pkg::*;
#(
  parameter srst_prio_e SRST_PRIO = SP_UNGATED,
  parameter bit         SRST_ON   = 1'b1,
  parameter bit         BLOCK_WR  = 1'b0
) (
  input  logic clk_en_i,
  input  logic rd_en_i,
  input  logic srst_i,
  input  logic wr_active_i,
  output logic load_o,
  output logic srst_o
);
  logic srst_req;
  logic srst_gate;
  logic rd_req;

  assign srst_req = SRST_ON && srst_i && !(BLOCK_WR && wr_active_i);
  assign rd_req   = clk_en_i && rd_en_i;

  generate
    if (SRST_PRIO == SP_UNGATED) begin : g_ungated
      assign srst_gate = 1'b1;
    end else if (SRST_PRIO == SP_GATE_CE) begin : g_gate_ce
      assign srst_gate = clk_en_i;
    end else begin : g_gate_re
      assign srst_gate = rd_req;
    end
  endgenerate

  assign srst_o = srst_req && srst_gate;
  assign load_o = rd_req && !srst_o;
endmodule

// File: rtl/rdreg_stage.sv
module rdreg_stage #(
  parameter int               WIDTH  = 8,
  parameter logic [WIDTH-1:0] INIT_Q = '0,
  parameter logic [WIDTH-1:0] ARST_Q = '0,
  parameter logic [WIDTH-1:0] SRST_Q = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arst_i,
  input  logic             srst_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge arst_i) begin
    if (!rst_ni)      q_o <= INIT_Q;
    else if (arst_i)  q_o <= ARST_Q;
    else if (srst_i)  q_o <= SRST_Q;
    else if (load_i)  q_o <= d_i;
  end
endmodule

// File: rtl/rd_out_reg.sv
module rd_out_reg
  import rdreg_pkg::*;
#(
  parameter int               WIDTH         = 8,
  parameter rst_kind_e        INIT_KIND     = RK_VALUE,
  parameter logic [WIDTH-1:0] INIT_VAL      = '0,
  parameter rst_kind_e        ARST_KIND     = RK_ZERO,
  parameter logic [WIDTH-1:0] ARST_VAL      = '0,
  parameter rst_kind_e        SRST_KIND     = RK_ZERO,
  parameter logic [WIDTH-1:0] SRST_VAL      = '0,
  parameter srst_prio_e       SRST_PRIO     = SP_UNGATED,
  parameter bit               SRST_BLOCK_WR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arst_i,
  input  logic             clk_en_i,
  input  logic             rd_en_i,
  input  logic             srst_i,
  input  logic             wr_active_i,
  input  logic [WIDTH-1:0] arr_data_i,
  output logic [WIDTH-1:0] rd_data_o
);
  // unspecified power-up content is realised as zero
  localparam logic [WIDTH-1:0] INIT_Q = (INIT_KIND == RK_VALUE) ? INIT_VAL : '0;
  localparam logic [WIDTH-1:0] ARST_Q = (ARST_KIND == RK_VALUE) ? ARST_VAL :
                                        (ARST_KIND == RK_INIT)  ? INIT_Q   : '0;
  localparam logic [WIDTH-1:0] SRST_Q = (SRST_KIND == RK_VALUE) ? SRST_VAL :
                                        (SRST_KIND == RK_INIT)  ? INIT_Q   : '0;
  localparam bit ARST_ON = (ARST_KIND != RK_NONE);
  localparam bit SRST_ON = (SRST_KIND != RK_NONE);

  logic arst_eff;
  logic load;
  logic srst_do;

  assign arst_eff = ARST_ON && arst_i;

  rdreg_ctrl #(
    .SRST_PRIO (SRST_PRIO),
    .SRST_ON   (SRST_ON),
    .BLOCK_WR  (SRST_BLOCK_WR)
  ) u_ctrl (
    .clk_en_i    (clk_en_i),
    .rd_en_i     (rd_en_i),
    .srst_i      (srst_i),
    .wr_active_i (wr_active_i),
    .load_o      (load),
    .srst_o      (srst_do)
  );

  rdreg_stage #(
    .WIDTH  (WIDTH),
    .INIT_Q (INIT_Q),
    .ARST_Q (ARST_Q),
    .SRST_Q (SRST_Q)
  ) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arst_i (arst_eff),
    .srst_i (srst_do),
    .load_i (load),
    .d_i    (arr_data_i),
    .q_o    (rd_data_o)
  );
endmodule

// File: rtl/rd_out_reg_chk.sv
module rd_out_reg_chk
  import rdreg_pkg::*;
#(
  parameter int               WIDTH         = 8,
  parameter rst_kind_e        INIT_KIND     = RK_VALUE,
  parameter logic [WIDTH-1:0] INIT_VAL      = '0,
  parameter rst_kind_e        ARST_KIND     = RK_ZERO,
  parameter logic [WIDTH-1:0] ARST_VAL      = '0,
  parameter rst_kind_e        SRST_KIND     = RK_ZERO,
  parameter logic [WIDTH-1:0] SRST_VAL      = '0,
  parameter srst_prio_e       SRST_PRIO     = SP_UNGATED,
  parameter bit               SRST_BLOCK_WR = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arst_i,
  input logic             clk_en_i,
  input logic             rd_en_i,
  input logic             srst_i,
  input logic             wr_active_i,
  input logic [WIDTH-1:0] arr_data_i,
  input logic [WIDTH-1:0] rd_data_o
);
  localparam logic [WIDTH-1:0] PWR_V = (INIT_KIND == RK_VALUE) ? INIT_VAL : '0;
  localparam logic [WIDTH-1:0] ARST_V = (ARST_KIND == RK_ZERO) ? '0 :
                                        (ARST_KIND == RK_INIT) ? PWR_V : ARST_VAL;
  localparam logic [WIDTH-1:0] SRST_V = (SRST_KIND == RK_ZERO) ? '0 :
                                        (SRST_KIND == RK_INIT) ? PWR_V : SRST_VAL;
  localparam bit HAS_AR   = (ARST_KIND != RK_NONE);
  localparam bit HAS_SR   = (SRST_KIND != RK_NONE);
  localparam bit NEED_CE  = (SRST_PRIO != SP_UNGATED);
  localparam bit NEED_RE  = (SRST_PRIO == SP_GATE_RE);

  logic ar_on;
  logic sr_fire;
  assign ar_on   = HAS_AR && arst_i;
  assign sr_fire = HAS_SR && srst_i && !(SRST_BLOCK_WR && wr_active_i) &&
                   (!NEED_CE || clk_en_i) && (!NEED_RE || rd_en_i);

  // R2
  arst_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_on |-> rd_data_o == ARST_V);

  // R4
  read_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || ar_on)
    (clk_en_i && rd_en_i && !srst_i) |=> rd_data_o == $past(arr_data_i));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || ar_on)
    (!clk_en_i && !(srst_i && HAS_SR && !NEED_CE)) |=> $stable(rd_data_o));

  // R6, R7, R8, R10
  srst_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || ar_on)
    sr_fire |=> rd_data_o == SRST_V);

  // R9
  srst_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || ar_on)
    (SRST_BLOCK_WR && srst_i && wr_active_i && !(clk_en_i && rd_en_i)) |=> $stable(rd_data_o));
endmodule

bind rd_out_reg rd_out_reg_chk #(
  .WIDTH         (WIDTH),
  .INIT_KIND     (INIT_KIND),
  .INIT_VAL      (INIT_VAL),
  .ARST_KIND     (ARST_KIND),
  .ARST_VAL      (ARST_VAL),
  .SRST_KIND     (SRST_KIND),
  .SRST_VAL      (SRST_VAL),
  .SRST_PRIO     (SRST_PRIO),
  .SRST_BLOCK_WR (SRST_BLOCK_WR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .arst_i      (arst_i),
  .clk_en_i    (clk_en_i),
  .rd_en_i     (rd_en_i),
  .srst_i      (srst_i),
  .wr_active_i (wr_active_i),
  .arr_data_i  (arr_data_i),
  .rd_data_o   (rd_data_o)
);

// File: tb/rd_out_reg_bench.sv
module rd_out_reg_bench;
  import rdreg_pkg::*;

  localparam int N = 4;
  // per copy: priority, block-write, reset presence and expected constants
  localparam int       PRIO [N] = '{0, 1, 2, 0};
  localparam bit       BLK  [N] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam bit       HAR  [N] = '{1'b1, 1'b1, 1'b1, 1'b0};
  localparam bit       HSR  [N] = '{1'b1, 1'b1, 1'b1, 1'b0};
  localparam bit [7:0] PWRV [N] = '{8'hA5, 8'hC3, 8'h00, 8'h96};
  localparam bit [7:0] ARV  [N] = '{8'h3C, 8'hC3, 8'h00, 8'h00};
  localparam bit [7:0] SRV  [N] = '{8'h5A, 8'hC3, 8'h7E, 8'h00};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       arst_i = 1'b0;
  logic       clk_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic       srst_i = 1'b0;
  logic       wr_active_i = 1'b0;
  logic [7:0] arr_data_i = 8'h00;
  logic [7:0] q0, q1, q2, q3;
  logic [7:0] exp_q [N];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4ns clk_i = ~clk_i;

  rd_out_reg #(.WIDTH(8), .INIT_KIND(RK_VALUE), .INIT_VAL(8'hA5),
    .ARST_KIND(RK_VALUE), .ARST_VAL(8'h3C), .SRST_KIND(RK_VALUE), .SRST_VAL(8'h5A),
    .SRST_PRIO(SP_UNGATED), .SRST_BLOCK_WR(1'b0)) u_rd_out_reg (
    .clk_i, .rst_ni, .arst_i, .clk_en_i, .rd_en_i, .srst_i, .wr_active_i,
    .arr_data_i, .rd_data_o(q0));

  rd_out_reg #(.WIDTH(8), .INIT_KIND(RK_VALUE), .INIT_VAL(8'hC3),
    .ARST_KIND(RK_INIT), .ARST_VAL(8'h11), .SRST_KIND(RK_INIT), .SRST_VAL(8'h22),
    .SRST_PRIO(SP_GATE_CE), .SRST_BLOCK_WR(1'b1)) u_rd_out_reg_ce (
    .clk_i, .rst_ni, .arst_i, .clk_en_i, .rd_en_i, .srst_i, .wr_active_i,
    .arr_data_i, .rd_data_o(q1));

  rd_out_reg #(.WIDTH(8), .INIT_KIND(RK_ZERO), .INIT_VAL(8'hFF),
    .ARST_KIND(RK_ZERO), .ARST_VAL(8'hFF), .SRST_KIND(RK_VALUE), .SRST_VAL(8'h7E),
    .SRST_PRIO(SP_GATE_RE), .SRST_BLOCK_WR(1'b0)) u_rd_out_reg_re (
    .clk_i, .rst_ni, .arst_i, .clk_en_i, .rd_en_i, .srst_i, .wr_active_i,
    .arr_data_i, .rd_data_o(q2));

  rd_out_reg #(.WIDTH(8), .INIT_KIND(RK_VALUE), .INIT_VAL(8'h96),
    .ARST_KIND(RK_NONE), .ARST_VAL(8'hEE), .SRST_KIND(RK_NONE), .SRST_VAL(8'hDD),
    .SRST_PRIO(SP_UNGATED), .SRST_BLOCK_WR(1'b1)) u_rd_out_reg_nr (
    .clk_i, .rst_ni, .arst_i, .clk_en_i, .rd_en_i, .srst_i, .wr_active_i,
    .arr_data_i, .rd_data_o(q3));

  function automatic logic [7:0] dout(int i);
    case (i)
      0:       return q0;
      1:       return q1;
      2:       return q2;
      default: return q3;
    endcase
  endfunction

  function automatic logic [7:0] model_next(int i, logic [7:0] q, logic [7:0] d,
                                            bit ce, bit re, bit sr, bit wr);
    bit ok;
    bit fire;
    ok = HSR[i] && sr && !(BLK[i] && wr);
    case (PRIO[i])
      0:       fire = ok;
      1:       fire = ok && ce;
      default: fire = ok && ce && re;
    endcase
    if (fire)          return SRV[i];
    else if (ce && re) return d;
    return q;
  endfunction

  task automatic check(string tag, int i, logic [7:0] act, logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s copy %0d: actual %h expected %h", tag, i, act, expv);
    end
  endtask

  task automatic step(string tag, logic [7:0] d, bit ce, bit re, bit sr, bit wr, bit ar);
    @(negedge clk_i);
    arr_data_i = d; clk_en_i = ce; rd_en_i = re;
    srst_i = sr; wr_active_i = wr; arst_i = ar;
    #1ns;
    if (ar) begin
      for (int i = 0; i < N; i++) begin
        if (HAR[i]) begin
          exp_q[i] = ARV[i];
          check({tag, " R2 async"}, i, dout(i), exp_q[i]);
        end else begin
          check({tag, " R3 async"}, i, dout(i), exp_q[i]);
        end
      end
    end
    @(posedge clk_i);
    for (int i = 0; i < N; i++)
      exp_q[i] = (ar && HAR[i]) ? ARV[i] : model_next(i, exp_q[i], d, ce, re, sr, wr);
    #1ns;
    for (int i = 0; i < N; i++) check(tag, i, dout(i), exp_q[i]);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #10ns;
    for (int i = 0; i < N; i++) begin
      exp_q[i] = PWRV[i];
      check("R1 power-up", i, dout(i), exp_q[i]);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    step("R4 read",                8'h11, 1, 1, 0, 0, 0);
    step("R5 hold ce low",         8'h22, 0, 1, 0, 0, 0);
    step("R5 hold re low",         8'h23, 1, 0, 0, 0, 0);
    step("R6 R7 R8 srst no en",    8'h24, 0, 0, 1, 0, 0);
    step("R4 reload",              8'h25, 1, 1, 0, 0, 0);
    step("R7 R10 srst ce only",    8'h26, 1, 0, 1, 0, 0);
    step("R8 R11 srst both en",    8'h33, 1, 1, 1, 0, 0);
    step("R6 srst re only",        8'h34, 0, 1, 1, 0, 0);
    step("R4 read",                8'h44, 1, 1, 0, 0, 0);
    step("R9 srst during write",   8'h55, 1, 1, 1, 1, 0);
    step("R9 blocked hold",        8'h56, 0, 0, 1, 1, 0);
    step("R11 write no srst",      8'h57, 1, 1, 0, 1, 0);
    step("R2 R3 async pulse",      8'h66, 1, 1, 1, 0, 1);
    step("R2 async held",          8'h67, 1, 1, 0, 0, 1);
    step("R4 after async",         8'h68, 1, 1, 0, 0, 0);

    for (int k = 0; k < 600; k++) begin
      logic [7:0] d;
      bit ce, re, sr, wr, ar;
      d  = 8'($urandom);
      ce = 1'($urandom);
      re = 1'($urandom);
      sr = ($urandom % 3) == 0;
      wr = 1'($urandom);
      ar = ($urandom % 20) == 0;
      step("random R4 R5 R6 R7 R8 R9", d, ce, re, sr, wr, ar);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule